// File: doc/BRIEF.md
# Background Register-Map CRC Monitor

This block watches three configuration windows of a register file for unintended changes. It runs in the background. For each enabled window it reads the registers in ascending address order through a plain read port and feeds their bits into a 16-bit CRC one bit per clock, most significant bit first. At the end of a pass it compares the result with a reference value supplied by the host. A mismatch pulls that window's active-low fault flag to 0. The flag stays at 0 until the host writes 1 to clear it. The block takes no other action.

The scanner is a four-state machine:
- `SCAN_IDLE` picks the next enabled window in round-robin order, loads the CRC seed and moves to `SCAN_FETCH`. It stays in `SCAN_IDLE` while no window is enabled.
- `SCAN_FETCH` issues the read of the first register. It moves to `SCAN_SHIFT`, or back to `SCAN_IDLE` if the window has been disabled.
- `SCAN_SHIFT` consumes one bit per clock. In the cycle of the last bit of each word it reads the following register. It moves to `SCAN_CHECK` after the final bit, or aborts to `SCAN_IDLE` when the window is disabled.
- `SCAN_CHECK` compares the CRC with the reference and always returns to `SCAN_IDLE`.

Registers outside the three windows, including every status register, are never read.

Top module: `regmap_crc_monitor`

## Requirements
- R1: Reads go only to the windows 40h–59h (window 1), 80h–A3h (window 2) and C0h–E3h (window 3). No other address is ever read.
- R2: A pass reads its window's registers from the lowest address to the highest, one read per 16-bit word. The returned word arrives one cycle after `rd_en` and is consumed MSB first.
- R3: Every pass starts with the CRC register at FFFFh, including a pass that restarts after an abort.
- R4: `poly_sel`=0 selects polynomial 1021h and `poly_sel`=1 selects 8005h. The shift is MSB-first with no reflection and no final XOR.
- R5: A pass over a window of N registers takes 1 fetch cycle, then 16·N shift cycles, then 1 compare cycle. `rd_en` is high in the fetch cycle and in the shift cycle of the last bit of every word except the final one.
- R6: If the final CRC differs from the window's reference, that window's flag (`fault_n` bit 0 = window 1, bit 1 = window 2, bit 2 = window 3) becomes 0 at the edge that ends the compare cycle. It stays 0 afterwards.
- R7: A 1 on a `flag_clr` bit sets that flag back to 1 at the next edge. A mismatch in the same cycle wins, and the flag stays 0.
- R8: A window whose enable is low never produces a new fault. Disabling a window mid-pass discards its partial CRC, and its next pass starts from the seed.
- R9: Only enabled windows are visited, in the order 1, 2, 3, 1, …, starting after the window visited last. With no window enabled, `rd_en` stays low.
- R10: A synchronous reset sets every flag to 1, returns the scanner to idle with the CRC at FFFFh, and makes window 1 the first candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | output | 1 | Register-file read strobe |
| rd_addr | output | 8 | Register-file read address |
| rd_data | input | 16 | Read data, valid one cycle after `rd_en` |
| sec_en | input | 3 | Per-window scan enable |
| ref_s1 | input | 16 | Reference CRC for window 1 |
| ref_s2 | input | 16 | Reference CRC for window 2 |
| ref_s3 | input | 16 | Reference CRC for window 3 |
| poly_sel | input | 1 | Polynomial select (0: 1021h, 1: 8005h) |
| flag_clr | input | 3 | Write-one-to-clear pulses for the flags |
| fault_n | output | 3 | Sticky active-low fault flags |

## Verification
The assertions assume that the register file returns data exactly one cycle after each read strobe. They also assume that `sec_en`, `flag_clr` and the references change only between clock edges and never carry X after reset. The bench models the register file as a synchronous memory with that latency and drives every input at the falling edge. It changes contents, references and the polynomial while passes are running, so a pass that straddles a change produces a genuine fault rather than a false assertion.

// File: rtl/regmap_crc_pkg.sv
package regmap_crc_pkg;

    localparam int NUM_SEC = 3;
    localparam int SEC_IW  = 2;
    localparam int CRC_W   = 16;

    localparam logic [CRC_W-1:0] CRC_SEED   = 16'hFFFF;
    localparam logic [CRC_W-1:0] POLY_CCITT = 16'h1021;
    localparam logic [CRC_W-1:0] POLY_ANSI  = 16'h8005;

    typedef enum logic [1:0] {
        SCAN_IDLE,
        SCAN_FETCH,
        SCAN_SHIFT,
        SCAN_CHECK
    } scan_state_t;

    typedef logic [SEC_IW-1:0] sec_idx_t;

endpackage

// File: rtl/regmap_crc_step.sv
// One serial CRC step, MSB first, no reflection.
module regmap_crc_step
    import regmap_crc_pkg::*;
#(
    parameter int            W       = CRC_W,
    parameter logic [W-1:0]  POLY_LO = POLY_CCITT,
    parameter logic [W-1:0]  POLY_HI = POLY_ANSI
) (
    input  logic [W-1:0] crc_in,
    input  logic         bit_in,
    input  logic         poly_sel,
    output logic [W-1:0] crc_out
);

    logic [W-1:0] poly;
    logic         feedback;

    always_comb begin
        poly     = poly_sel ? POLY_HI : POLY_LO;
        feedback = crc_in[W-1] ^ bit_in;
        crc_out  = {crc_in[W-2:0], 1'b0} ^ (feedback ? poly : '0);
    end

endmodule

// File: rtl/regmap_rr_pick.sv
// Round-robin pick of the first requesting index at or after 'start'.
module regmap_rr_pick #(
    parameter int N  = 3,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] grant
);

    always_comb begin
        found = 1'b0;
        grant = start;
        // walk backwards so that the nearest candidate is written last
        for (int k = N - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(start) + k) % N;
            if (req[idx]) begin
                found = 1'b1;
                grant = IW'(idx);
            end
        end
    end

endmodule

// File: rtl/regmap_fault_bank.sv
// Sticky active-low flags: set wins over clear.
module regmap_fault_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_mask,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags_n
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_n[g] <= 1'b1;
            end else if (set_mask[g]) begin
                flags_n[g] <= 1'b0;
            end else if (clr_mask[g]) begin
                flags_n[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/regmap_crc_monitor.sv
module regmap_crc_monitor
    import regmap_crc_pkg::*;
#(
    parameter int                DATA_W   = 16,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] S1_FIRST = 8'h40,
    parameter logic [ADDR_W-1:0] S1_LAST  = 8'h59,
    parameter logic [ADDR_W-1:0] S2_FIRST = 8'h80,
    parameter logic [ADDR_W-1:0] S2_LAST  = 8'hA3,
    parameter logic [ADDR_W-1:0] S3_FIRST = 8'hC0,
    parameter logic [ADDR_W-1:0] S3_LAST  = 8'hE3
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic                 rd_en,
    output logic [ADDR_W-1:0]    rd_addr,
    input  logic [DATA_W-1:0]    rd_data,
    input  logic [NUM_SEC-1:0]   sec_en,
    input  logic [CRC_W-1:0]     ref_s1,
    input  logic [CRC_W-1:0]     ref_s2,
    input  logic [CRC_W-1:0]     ref_s3,
    input  logic                 poly_sel,
    input  logic [NUM_SEC-1:0]   flag_clr,
    output logic [NUM_SEC-1:0]   fault_n
);

    localparam int               BIT_W   = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(DATA_W - 1);

    function automatic logic [ADDR_W-1:0] first_of(sec_idx_t s);
        case (s)
            2'd0:    return S1_FIRST;
            2'd1:    return S2_FIRST;
            default: return S3_FIRST;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] last_of(sec_idx_t s);
        case (s)
            2'd0:    return S1_LAST;
            2'd1:    return S2_LAST;
            default: return S3_LAST;
        endcase
    endfunction

    function automatic sec_idx_t after(sec_idx_t s);
        return (s == sec_idx_t'(NUM_SEC - 1)) ? '0 : s + sec_idx_t'(1);
    endfunction

    scan_state_t        state_q, state_d;
    sec_idx_t           cur_q, ptr_q, pick;
    logic               pick_ok;
    logic [ADDR_W-1:0]  addr_q;
    logic [BIT_W-1:0]   bitcnt_q;
    logic [DATA_W-1:0]  sreg_q, word_now;
    logic [CRC_W-1:0]   crc_q, crc_next, ref_cur;
    logic               cur_en, bit_now, word_end, last_word, mismatch;
    logic [NUM_SEC-1:0] set_mask;

    regmap_rr_pick #(.N(NUM_SEC), .IW(SEC_IW)) u_pick (
        .req   (sec_en),
        .start (ptr_q),
        .found (pick_ok),
        .grant (pick)
    );

    regmap_crc_step #(.W(CRC_W), .POLY_LO(POLY_CCITT), .POLY_HI(POLY_ANSI)) u_step (
        .crc_in   (crc_q),
        .bit_in   (bit_now),
        .poly_sel (poly_sel),
        .crc_out  (crc_next)
    );

    regmap_fault_bank #(.N(NUM_SEC)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_mask (set_mask),
        .clr_mask (flag_clr),
        .flags_n  (fault_n)
    );

    // datapath decode
    always_comb begin
        cur_en    = sec_en[cur_q];
        word_now  = (bitcnt_q == BIT_TOP) ? rd_data : sreg_q;
        bit_now   = word_now[DATA_W-1];
        word_end  = (bitcnt_q == '0);
        last_word = (addr_q == last_of(cur_q));
        case (cur_q)
            2'd0:    ref_cur = ref_s1;
            2'd1:    ref_cur = ref_s2;
            default: ref_cur = ref_s3;
        endcase
        mismatch = (state_q == SCAN_CHECK) && cur_en && (crc_q != ref_cur);
        set_mask = '0;
        if (mismatch) begin
            set_mask[cur_q] = 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCAN_IDLE: begin
                if (pick_ok) state_d = SCAN_FETCH;
            end
            SCAN_FETCH: begin
                state_d = cur_en ? SCAN_SHIFT : SCAN_IDLE;
            end
            SCAN_SHIFT: begin
                if (!cur_en)                    state_d = SCAN_IDLE;
                else if (word_end && last_word) state_d = SCAN_CHECK;
            end
            SCAN_CHECK: begin
                state_d = SCAN_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SCAN_IDLE;
        else     state_q <= state_d;
    end

    // scan position and CRC register
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '0;
            ptr_q    <= '0;
            addr_q   <= S1_FIRST;
            bitcnt_q <= BIT_TOP;
            sreg_q   <= '0;
            crc_q    <= CRC_SEED;
        end else begin
            unique case (state_q)
                SCAN_IDLE: begin
                    if (pick_ok) begin
                        cur_q    <= pick;
                        addr_q   <= first_of(pick);
                        bitcnt_q <= BIT_TOP;
                        crc_q    <= CRC_SEED;
                    end
                end
                SCAN_FETCH: begin
                    if (!cur_en) ptr_q <= after(cur_q);
                end
                SCAN_SHIFT: begin
                    if (!cur_en) begin
                        ptr_q <= after(cur_q);
                    end else begin
                        crc_q  <= crc_next;
                        sreg_q <= {word_now[DATA_W-2:0], 1'b0};
                        if (word_end) begin
                            bitcnt_q <= BIT_TOP;
                            if (!last_word) addr_q <= addr_q + ADDR_W'(1);
                        end else begin
                            bitcnt_q <= bitcnt_q - BIT_W'(1);
                        end
                    end
                end
                SCAN_CHECK: begin
                    ptr_q <= after(cur_q);
                end
            endcase
        end
    end

    // outputs: read port
    always_comb begin
        rd_en   = (state_q == SCAN_FETCH) ||
                  ((state_q == SCAN_SHIFT) && word_end && !last_word);
        rd_addr = (state_q == SCAN_SHIFT) ? addr_q + ADDR_W'(1) : addr_q;
    end

endmodule

// File: rtl/regmap_crc_monitor_chk.sv
module regmap_crc_monitor_chk
    import regmap_crc_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] S1_FIRST = 8'h40,
    parameter logic [ADDR_W-1:0] S1_LAST  = 8'h59,
    parameter logic [ADDR_W-1:0] S2_FIRST = 8'h80,
    parameter logic [ADDR_W-1:0] S2_LAST  = 8'hA3,
    parameter logic [ADDR_W-1:0] S3_FIRST = 8'hC0,
    parameter logic [ADDR_W-1:0] S3_LAST  = 8'hE3
) (
    input logic               clk,
    input logic               rst,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [NUM_SEC-1:0] sec_en,
    input logic [NUM_SEC-1:0] flag_clr,
    input logic [NUM_SEC-1:0] fault_n,
    input scan_state_t        state_q,
    input logic [CRC_W-1:0]   crc_q
);

    logic in_win;
    assign in_win = (rd_addr >= S1_FIRST && rd_addr <= S1_LAST) ||
                    (rd_addr >= S2_FIRST && rd_addr <= S2_LAST) ||
                    (rd_addr >= S3_FIRST && rd_addr <= S3_LAST);

    p_read_in_window_r1: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> in_win);

    p_read_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);

    p_seed_at_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == SCAN_FETCH) |-> (crc_q == CRC_SEED));

    p_fall_after_check_w1_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_n[0]) |-> ($past(state_q) == SCAN_CHECK));
    p_fall_after_check_w2_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_n[1]) |-> ($past(state_q) == SCAN_CHECK));
    p_fall_after_check_w3_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_n[2]) |-> ($past(state_q) == SCAN_CHECK));

    p_clear_w1_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_clr[0] && state_q != SCAN_CHECK) |=> fault_n[0]);
    p_clear_w2_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_clr[1] && state_q != SCAN_CHECK) |=> fault_n[1]);
    p_clear_w3_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_clr[2] && state_q != SCAN_CHECK) |=> fault_n[2]);

    p_disabled_quiet_w1_r8: assert property (@(posedge clk) disable iff (rst)
        (!sec_en[0] && fault_n[0]) |=> fault_n[0]);
    p_disabled_quiet_w2_r8: assert property (@(posedge clk) disable iff (rst)
        (!sec_en[1] && fault_n[1]) |=> fault_n[1]);
    p_disabled_quiet_w3_r8: assert property (@(posedge clk) disable iff (rst)
        (!sec_en[2] && fault_n[2]) |=> fault_n[2]);

    p_idle_no_read_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == SCAN_IDLE) |-> !rd_en);

    p_reset_state_r10: assert property (@(posedge clk)
        rst |=> ((fault_n == 3'b111) && (state_q == SCAN_IDLE)));

endmodule

bind regmap_crc_monitor regmap_crc_monitor_chk #(
    .ADDR_W   (ADDR_W),
    .S1_FIRST (S1_FIRST), .S1_LAST (S1_LAST),
    .S2_FIRST (S2_FIRST), .S2_LAST (S2_LAST),
    .S3_FIRST (S3_FIRST), .S3_LAST (S3_LAST)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .sec_en   (sec_en),
    .flag_clr (flag_clr),
    .fault_n  (fault_n),
    .state_q  (state_q),
    .crc_q    (crc_q)
);

// File: tb/regmap_crc_monitor_bench.sv
`timescale 1ns/1ps
module regmap_crc_monitor_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en;
    logic [7:0]  rd_addr;
    logic [15:0] rd_data = '0;
    logic [2:0]  sec_en = '0;
    logic [15:0] ref_s1 = '0, ref_s2 = '0, ref_s3 = '0;
    logic        poly_sel = 1'b0;
    logic [2:0]  flag_clr = '0;
    logic [2:0]  fault_n;

    always #4 clk = ~clk;

    regmap_crc_monitor u_regmap_crc_monitor (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .sec_en(sec_en), .ref_s1(ref_s1), .ref_s2(ref_s2), .ref_s3(ref_s3),
        .poly_sel(poly_sel), .flag_clr(flag_clr), .fault_n(fault_n)
    );

    // register file: one-cycle read latency
    logic [15:0] mem [256];
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    int total = 0;
    int bad = 0;
    int oow = 0;
    int w2_reads = 0;
    bit finished = 1'b0;
    bit live = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int w_first(int s);
        return (s == 0) ? 'h40 : (s == 1) ? 'h80 : 'hC0;
    endfunction
    function automatic int w_last(int s);
        return (s == 0) ? 'h59 : (s == 1) ? 'hA3 : 'hE3;
    endfunction
    function automatic int w_bits(int s);
        return (w_last(s) - w_first(s) + 1) * 16;
    endfunction
    function automatic logic [15:0] crc_bit(logic [15:0] c, logic b, logic p);
        logic [15:0] n;
        n = {c[14:0], 1'b0};
        if (c[15] ^ b) n = n ^ (p ? 16'h8005 : 16'h1021);
        return n;
    endfunction
    function automatic logic [15:0] calc(int s, logic p);
        logic [15:0] c = 16'hFFFF;
        for (int a = w_first(s); a <= w_last(s); a++)
            for (int b = 15; b >= 0; b--) c = crc_bit(c, mem[a][b], p);
        return c;
    endfunction
    function automatic logic [15:0] ref_of(int s);
        return (s == 0) ? ref_s1 : (s == 1) ? ref_s2 : ref_s3;
    endfunction

    // behavioural reference model: 0 idle, 1 fetch, 2 shift, 3 compare
    int          m_st, m_cur, m_ptr, m_pos;
    bit          m_found;
    logic [15:0] m_crc, m_word;
    logic [2:0]  m_fault, m_set;

    always @(posedge clk) begin
        live = 1'b1;
        if (rst) begin
            m_st = 0; m_cur = 0; m_ptr = 0; m_pos = 0;
            m_crc = 16'hFFFF; m_word = '0; m_fault = 3'b111;
        end else begin
            m_set = 3'b000;
            case (m_st)
                0: begin
                    m_found = 1'b0;
                    for (int k = 0; k < 3; k++)
                        if (!m_found && sec_en[(m_ptr + k) % 3]) begin
                            m_found = 1'b1;
                            m_cur = (m_ptr + k) % 3;
                        end
                    if (m_found) begin m_st = 1; m_pos = 0; m_crc = 16'hFFFF; end
                end
                1: if (!sec_en[m_cur]) begin m_st = 0; m_ptr = (m_cur + 1) % 3; end
                   else m_st = 2;
                2: if (!sec_en[m_cur]) begin
                       m_st = 0; m_ptr = (m_cur + 1) % 3;
                   end else begin
                       if (m_pos % 16 == 0) m_word = rd_data;
                       m_crc = crc_bit(m_crc, m_word[15 - m_pos % 16], poly_sel);
                       m_pos++;
                       if (m_pos == w_bits(m_cur)) m_st = 3;
                   end
                default: begin
                    if (sec_en[m_cur] && m_crc != ref_of(m_cur)) m_set[m_cur] = 1'b1;
                    m_ptr = (m_cur + 1) % 3;
                    m_st = 0;
                end
            endcase
            for (int i = 0; i < 3; i++) begin
                if (m_set[i])           m_fault[i] = 1'b0;
                else if (flag_clr[i])   m_fault[i] = 1'b1;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (live) begin
            bit e_en;
            int e_addr;
            e_en = (m_st == 1) ||
                   (m_st == 2 && m_pos % 16 == 15 && m_pos + 1 < w_bits(m_cur));
            e_addr = w_first(m_cur) + ((m_st == 1) ? 0 : (m_pos + 1) / 16);
            chk(fault_n === m_fault, "R6/R7", "fault_n per clock", 32'(fault_n), 32'(m_fault));
            chk(rd_en === e_en, "R5/R9", "rd_en per clock", 32'(rd_en), 32'(e_en));
            if (e_en && rd_en)
                chk(rd_addr === 8'(e_addr), "R1/R2", "rd_addr per clock", 32'(rd_addr), 32'(e_addr));
            if (rd_en && !((rd_addr >= 8'h40 && rd_addr <= 8'h59) ||
                           (rd_addr >= 8'h80 && rd_addr <= 8'hA3) ||
                           (rd_addr >= 8'hC0 && rd_addr <= 8'hE3)))
                oow++;
            if (rd_en && rd_addr >= 8'h80 && rd_addr <= 8'hA3) w2_reads++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam int ROUND2 = 3300;

    initial begin
        bit seen;
        for (int a = 0; a < 256; a++) mem[a] = 16'((a * 40503) ^ 16'hC3A1);
        tick(3);
        chk(fault_n === 3'b111, "R10", "flags after reset", 32'(fault_n), 32'h7);
        chk(rd_en === 1'b0, "R10", "no read in reset", 32'(rd_en), 0);
        rst = 1'b0;
        tick(50);
        chk(rd_en === 1'b0, "R9", "idle with nothing enabled", 32'(rd_en), 0);

        // R3 R4: matching CCITT references
        ref_s1 = calc(0, 1'b0); ref_s2 = calc(1, 1'b0); ref_s3 = calc(2, 1'b0);
        sec_en = 3'b111;
        tick(ROUND2);
        chk(fault_n === 3'b111, "R3/R4", "clean CCITT scan", 32'(fault_n), 32'h7);

        // R6: corruption in window 1, sticky after repair
        mem[8'h45] = mem[8'h45] ^ 16'h0100;
        tick(ROUND2);
        chk(fault_n === 3'b110, "R6", "window 1 corrupted", 32'(fault_n), 32'h6);
        mem[8'h45] = mem[8'h45] ^ 16'h0100;
        tick(ROUND2);
        chk(fault_n[0] === 1'b0, "R6", "flag sticky after repair", 32'(fault_n[0]), 0);
        flag_clr = 3'b001; tick(1); flag_clr = 3'b000;
        chk(fault_n[0] === 1'b1, "R7", "write-one clear", 32'(fault_n[0]), 1);
        tick(ROUND2);
        chk(fault_n === 3'b111, "R7", "stays clear", 32'(fault_n), 32'h7);

        // R10: reset while a fault is pending
        mem[8'hD0] = ~mem[8'hD0];
        tick(ROUND2);
        chk(fault_n[2] === 1'b0, "R6", "window 3 corrupted", 32'(fault_n[2]), 0);
        mem[8'hD0] = ~mem[8'hD0];
        rst = 1'b1; tick(2);
        chk(fault_n === 3'b111, "R10", "flags after mid-run reset", 32'(fault_n), 32'h7);
        rst = 1'b0; tick(1);
        chk(rd_en === 1'b1 && rd_addr === 8'h40, "R10", "restart at window 1",
            {23'd0, rd_en, rd_addr}, 32'h140);
        tick(ROUND2);

        // R4: polynomial switch
        poly_sel = 1'b1;
        tick(ROUND2);
        chk(fault_n === 3'b000, "R4", "8005h against 1021h references", 32'(fault_n), 0);
        ref_s1 = calc(0, 1'b1); ref_s2 = calc(1, 1'b1); ref_s3 = calc(2, 1'b1);
        tick(ROUND2);
        flag_clr = 3'b111; tick(1); flag_clr = 3'b000;
        tick(ROUND2);
        chk(fault_n === 3'b111, "R4", "clean 8005h scan", 32'(fault_n), 32'h7);

        // R8 R9: disabled window never faults and is never read
        sec_en = 3'b101; ref_s2 = ~ref_s2;
        tick(1); w2_reads = 0;
        tick(ROUND2);
        chk(fault_n === 3'b111, "R8", "disabled window quiet", 32'(fault_n), 32'h7);
        chk(w2_reads == 0, "R9", "disabled window skipped", 32'(w2_reads), 0);
        ref_s2 = calc(1, 1'b1);

        // R8 R3: abort mid-pass, restart from seed
        sec_en = 3'b100;
        tick(200);
        sec_en = 3'b000;
        tick(5);
        chk(rd_en === 1'b0, "R9", "no reads after disable", 32'(rd_en), 0);
        sec_en = 3'b100;
        tick(1400);
        chk(fault_n === 3'b111, "R8/R3", "restarted pass clean", 32'(fault_n), 32'h7);

        // R7: clear held during a mismatch loses
        ref_s3 = ~ref_s3; flag_clr = 3'b100; seen = 1'b0;
        for (int i = 0; i < 1500; i++) begin
            tick(1);
            if (fault_n[2] === 1'b0) seen = 1'b1;
        end
        chk(seen, "R7", "mismatch beats clear", 32'(seen), 1);
        flag_clr = 3'b000; ref_s3 = calc(2, 1'b1);
        tick(700);
        flag_clr = 3'b100; tick(1); flag_clr = 3'b000;
        chk(fault_n === 3'b111, "R7", "cleared after repair", 32'(fault_n), 32'h7);

        sec_en = 3'b000;
        tick(10);
        chk(rd_en === 1'b0, "R9", "idle again", 32'(rd_en), 0);
        chk(oow == 0, "R1", "reads outside windows", 32'(oow), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule